// File: doc/BRIEF.md
# Shifter Operand Generator

This block produces the second operand of a data-processing instruction in a 32-bit load/store core. It decodes the low twelve bits of the instruction word together with a separate immediate-select bit. From those bits it builds a shifted or rotated copy of the Rm register value, or a rotated 8-bit constant. It also returns the shifter carry-out that the ALU uses for the carry flag of logical operations. Register read values and the incoming carry flag arrive already read. The block is purely combinational.

When the shift amount comes from a register, the core needs one more execution cycle. The block raises a flag for that case. In the same case, an operand that was read from the program counter is increased by a fixed bump, because the pipeline has moved on by the time that read happens. The encodings hold several corner cases: a zero amount, amounts of 32 and above, an immediate field of zero that stands for a shift by 32 or for a one-bit rotate through carry, and the carry rule of the rotated constant. Each of these is handled explicitly.

Top module: `shifter_operand_gen`

## Requirements
- R1: In register form (`imm_sel`=0, `op_field[4]`=1), the amount is the low 8 bits of `rs_val`, read after the PC bump. `extra_cycle` is 1 in this form only. `rm_val` and `rs_val` each gain +4 when their `*_is_pc` input is set, and only in this form.
- R2: A register-form amount of zero returns `rm` unchanged, with `carry_out` = `carry_in`. This holds for every shift kind.
- R3: Logical left (kind `op_field[6:5]`=00) works as follows. For 1..31 the result is `rm << n` and the carry is bit 32-n. For exactly 32 the result is 0 and the carry is bit 0. Above 32 both the result and the carry are 0.
- R4: Logical right (kind 01) works as follows. For 1..31 the result is `rm >> n` and the carry is bit n-1. For exactly 32 the result is 0 and the carry is bit 31. Above 32 both are 0. An immediate amount field (`op_field[11:7]`) of 0 means 32.
- R5: Arithmetic right (kind 10) by 32 or more fills the result with the sign bit and makes the carry equal to the sign bit. An immediate field of 0 means 32. For 1..31 the carry is bit n-1.
- R6: Rotate right (kind 11) in register form uses amount bits 4:0. A rotation r>0 gives the carry from bit r-1. A nonzero amount whose low five bits are zero leaves `rm` unchanged, with the carry taken from bit 31.
- R7: Rotate right with an immediate field of 0 is a one-bit rotate through carry. `carry_in` enters bit 31, and old bit 0 becomes `carry_out`.
- R8: Logical left with an immediate field of 0 returns `rm` unchanged, with `carry_out` = `carry_in`.
- R9: With `imm_sel`=1, the result is `op_field[7:0]` rotated right by twice `op_field[11:8]`. The carry is `carry_in` when that field is 0, and result bit 31 otherwise. `extra_cycle` is 0.
- R10: With all inputs at zero, the outputs are operand 0, carry 0 and no extra cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| imm_sel | input | 1 | Selects the rotated 8-bit constant form |
| op_field | input | 12 | Operand field, instruction bits 11:0 |
| rm_val | input | 32 | Value read for Rm |
| rs_val | input | 32 | Value read for Rs |
| rm_is_pc | input | 1 | Rm is the program counter |
| rs_is_pc | input | 1 | Rs is the program counter |
| carry_in | input | 1 | Current carry flag |
| operand | output | 32 | Generated second operand |
| carry_out | output | 1 | Shifter carry-out |
| extra_cycle | output | 1 | Register-amount form needs one more cycle |

## Verification
Every time the inputs settle, the checker confirms several properties. A zero register amount passes the value and the carry through. Logical left beyond 32 yields zero. Arithmetic right at 32 and above fills with the sign bit. The one-bit rotate through carry moves the right bits. An unrotated constant keeps the incoming carry. The constant form never asks for an extra cycle. Only the bench scenarios can show the exact carry-bit positions for amounts below 32, the boundary between 32 and 33, rotations by multiples of 32, and the PC bump applying in register form but not in immediate form, because each of these depends on specific operand bit patterns.

// File: rtl/sop_pkg.sv
package sop_pkg;
   // shift kind as decoded from operand field bits 6:5
   typedef enum logic [1:0] {
      SH_LSL = 2'd0,
      SH_LSR = 2'd1,
      SH_ASR = 2'd2,
      SH_ROR = 2'd3
   } shift_kind_e;

   localparam int OP_FIELD_W = 12;
   localparam int IMM_AMT_W  = 5;
endpackage

// File: rtl/sop_amount.sv
module sop_amount
   import sop_pkg::*;
#(
   parameter int W       = 32,
   parameter int AMT_W   = 8,
   parameter int PC_BUMP = 4
) (
   input  logic [OP_FIELD_W-1:0] op_field,
   input  logic [W-1:0]          rm_val,
   input  logic [W-1:0]          rs_val,
   input  logic                  rm_is_pc,
   input  logic                  rs_is_pc,
   output logic [W-1:0]          src_val,
   output logic [AMT_W-1:0]      amount,
   output shift_kind_e           kind,
   output logic                  rrx
);
   localparam logic [W-1:0]     BUMP    = W'(PC_BUMP);
   localparam logic [AMT_W-1:0] FULL_SH = AMT_W'(W);

   logic                 reg_form;
   logic [IMM_AMT_W-1:0] imm_amt;
   logic [W-1:0]         rs_eff;

   assign reg_form = op_field[4];
   assign imm_amt  = op_field[11:7];
   assign kind     = shift_kind_e'(op_field[6:5]);
   assign rs_eff   = rs_val + (rs_is_pc ? BUMP : '0);
   assign src_val  = (reg_form && rm_is_pc) ? rm_val + BUMP : rm_val;

   always_comb begin
      rrx    = 1'b0;
      amount = AMT_W'(imm_amt);
      if (reg_form) begin
         amount = rs_eff[AMT_W-1:0];
      end else if (imm_amt == '0) begin
         case (kind)
            SH_LSR, SH_ASR: amount = FULL_SH;
            SH_ROR:         rrx    = 1'b1;
            default:        amount = '0;
         endcase
      end
   end
endmodule

// File: rtl/sop_barrel.sv
module sop_barrel
   import sop_pkg::*;
#(
   parameter int W     = 32,
   parameter int AMT_W = 8
) (
   input  logic [W-1:0]     val,
   input  logic [AMT_W-1:0] amount,
   input  shift_kind_e      kind,
   input  logic             rrx,
   input  logic             carry_in,
   output logic [W-1:0]     result,
   output logic             carry
);
   localparam int ROT_W = $clog2(W);

   logic [W:0]        lsl_wide;
   logic [W:0]        rsh_wide;
   logic signed [W:0] sar_wide;
   logic [ROT_W-1:0]  rot;
   logic [W-1:0]      rotated;

   always_comb begin
      lsl_wide = {1'b0, val} << amount;
      rsh_wide = {val, 1'b0} >> amount;
      sar_wide = $signed({val, 1'b0}) >>> amount;
      rot      = amount[ROT_W-1:0];
      rotated  = (val >> rot) | (val << (W - int'(rot)));

      if (rrx) begin
         result = {carry_in, val[W-1:1]};
         carry  = val[0];
      end else if (amount == '0) begin
         result = val;
         carry  = carry_in;
      end else begin
         case (kind)
            SH_LSL: begin
               result = lsl_wide[W-1:0];
               carry  = lsl_wide[W];
            end
            SH_LSR: begin
               result = rsh_wide[W:1];
               carry  = rsh_wide[0];
            end
            SH_ASR: begin
               result = sar_wide[W:1];
               carry  = sar_wide[0];
            end
            default: begin
               result = rotated;
               carry  = rotated[W-1];
            end
         endcase
      end
   end
endmodule

// File: rtl/sop_rotimm.sv
module sop_rotimm
   import sop_pkg::*;
#(
   parameter int W     = 32,
   parameter int IMM_W = 8,
   parameter int RFW   = 4
) (
   input  logic [OP_FIELD_W-1:0] op_field,
   input  logic                  carry_in,
   output logic [W-1:0]          result,
   output logic                  carry
);
   localparam int ROT_W = $clog2(W);

   logic [RFW-1:0]   rot_f;
   logic [ROT_W-1:0] rot;
   logic [W-1:0]     base;

   assign rot_f  = op_field[IMM_W +: RFW];
   assign rot    = ROT_W'({rot_f, 1'b0});
   assign base   = W'(op_field[IMM_W-1:0]);
   assign result = (base >> rot) | (base << (W - int'(rot)));
   assign carry  = (rot_f == '0) ? carry_in : result[W-1];
endmodule

// File: rtl/shifter_operand_gen.sv
module shifter_operand_gen
   import sop_pkg::*;
#(
   parameter int W       = 32,
   parameter int AMT_W   = 8,
   parameter int PC_BUMP = 4
) (
   input  logic                  imm_sel,
   input  logic [OP_FIELD_W-1:0] op_field,
   input  logic [W-1:0]          rm_val,
   input  logic [W-1:0]          rs_val,
   input  logic                  rm_is_pc,
   input  logic                  rs_is_pc,
   input  logic                  carry_in,
   output logic [W-1:0]          operand,
   output logic                  carry_out,
   output logic                  extra_cycle
);
   generate
      if (W < 16 || (W & (W - 1)) != 0) begin : g_bad_width
         $error("shifter_operand_gen: W must be a power of two of at least 16");
      end
      if ((1 << AMT_W) <= W) begin : g_bad_amt
         $error("shifter_operand_gen: AMT_W too narrow to hold W");
      end
   endgenerate

   logic [W-1:0]     src_val;
   logic [AMT_W-1:0] amount;
   shift_kind_e      kind;
   logic             rrx;
   logic [W-1:0]     sh_result;
   logic             sh_carry;
   logic [W-1:0]     ri_result;
   logic             ri_carry;

   sop_amount #(.W(W), .AMT_W(AMT_W), .PC_BUMP(PC_BUMP)) u_amount (
      .op_field (op_field),
      .rm_val   (rm_val),
      .rs_val   (rs_val),
      .rm_is_pc (rm_is_pc),
      .rs_is_pc (rs_is_pc),
      .src_val  (src_val),
      .amount   (amount),
      .kind     (kind),
      .rrx      (rrx)
   );

   sop_barrel #(.W(W), .AMT_W(AMT_W)) u_barrel (
      .val      (src_val),
      .amount   (amount),
      .kind     (kind),
      .rrx      (rrx),
      .carry_in (carry_in),
      .result   (sh_result),
      .carry    (sh_carry)
   );

   sop_rotimm #(.W(W)) u_rotimm (
      .op_field (op_field),
      .carry_in (carry_in),
      .result   (ri_result),
      .carry    (ri_carry)
   );

   assign operand     = imm_sel ? ri_result : sh_result;
   assign carry_out   = imm_sel ? ri_carry  : sh_carry;
   assign extra_cycle = ~imm_sel & op_field[4];
endmodule

// File: rtl/sop_checker.sv
module sop_checker
   import sop_pkg::*;
#(
   parameter int W       = 32,
   parameter int AMT_W   = 8,
   parameter int PC_BUMP = 4
) (
   input logic                  imm_sel,
   input logic [OP_FIELD_W-1:0] op_field,
   input logic [W-1:0]          rm_val,
   input logic [W-1:0]          rs_val,
   input logic                  rm_is_pc,
   input logic                  rs_is_pc,
   input logic                  carry_in,
   input logic [W-1:0]          operand,
   input logic                  carry_out,
   input logic                  extra_cycle
);
   logic [W-1:0]     rm_eff;
   logic [W-1:0]     rs_eff;
   logic [AMT_W-1:0] ramt;
   logic             regf;

   always_comb begin
      rm_eff = rm_is_pc ? rm_val + W'(PC_BUMP) : rm_val;
      rs_eff = rs_is_pc ? rs_val + W'(PC_BUMP) : rs_val;
      ramt   = rs_eff[AMT_W-1:0];
      regf   = !imm_sel && op_field[4];

      if (imm_sel) begin
         assert_const_no_stall_R1: assert (!extra_cycle);
      end
      if (regf && ramt == '0) begin
         assert_zero_amt_pass_R2: assert (operand == rm_eff && carry_out == carry_in);
      end
      if (regf && op_field[6:5] == 2'b00 && int'(ramt) > W) begin
         assert_lsl_beyond_zero_R3: assert (operand == '0 && !carry_out);
      end
      if (regf && op_field[6:5] == 2'b10 && int'(ramt) >= W) begin
         assert_asr_sign_fill_R5: assert (operand == {W{rm_eff[W-1]}} && carry_out == rm_eff[W-1]);
      end
      if (!imm_sel && !op_field[4] && op_field[6:5] == 2'b11 && op_field[11:7] == '0) begin
         assert_rrx_bits_R7: assert (operand[W-1] == carry_in && carry_out == rm_val[0]);
      end
      if (imm_sel && op_field[11:8] == '0) begin
         assert_const_unrotated_R9: assert (operand == W'(op_field[7:0]) && carry_out == carry_in);
      end
   end
endmodule

bind shifter_operand_gen sop_checker #(.W(W), .AMT_W(AMT_W), .PC_BUMP(PC_BUMP)) u_chk (
   .imm_sel     (imm_sel),
   .op_field    (op_field),
   .rm_val      (rm_val),
   .rs_val      (rs_val),
   .rm_is_pc    (rm_is_pc),
   .rs_is_pc    (rs_is_pc),
   .carry_in    (carry_in),
   .operand     (operand),
   .carry_out   (carry_out),
   .extra_cycle (extra_cycle)
);

// File: tb/sim_shifter_operand_gen.sv
module sim_shifter_operand_gen;
   logic        clk = 1'b0;
   logic        imm_sel = 1'b0;
   logic [11:0] op_field = '0;
   logic [31:0] rm_val = '0;
   logic [31:0] rs_val = '0;
   logic        rm_is_pc = 1'b0;
   logic        rs_is_pc = 1'b0;
   logic        carry_in = 1'b0;
   logic [31:0] operand;
   logic        carry_out;
   logic        extra_cycle;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   shifter_operand_gen u0 (
      .imm_sel     (imm_sel),
      .op_field    (op_field),
      .rm_val      (rm_val),
      .rs_val      (rs_val),
      .rm_is_pc    (rm_is_pc),
      .rs_is_pc    (rs_is_pc),
      .carry_in    (carry_in),
      .operand     (operand),
      .carry_out   (carry_out),
      .extra_cycle (extra_cycle)
   );

   typedef struct packed {
      logic        imm;
      logic [11:0] op;
      logic [31:0] rm;
      logic [31:0] rs;
      logic        rmpc;
      logic        rspc;
      logic        cin;
      logic [31:0] eop;
      logic        ec;
      logic        ex;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 26;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 12'h200, 32'h1000_0001, 32'h0, 1'b0, 1'b0, 1'b0, 32'h0000_0010, 1'b1, 1'b0, 4'd3}, // R3 imm lsl 4
      '{1'b0, 12'h420, 32'h0000_0180, 32'h0, 1'b0, 1'b0, 1'b0, 32'h0000_0001, 1'b1, 1'b0, 4'd4}, // R4 imm lsr 8
      '{1'b0, 12'h020, 32'h8000_0000, 32'h0, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 1'b1, 1'b0, 4'd4}, // R4 imm lsr 0 -> 32
      '{1'b0, 12'h040, 32'h8000_1234, 32'h0, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF, 1'b1, 1'b0, 4'd5}, // R5 imm asr 0 neg
      '{1'b0, 12'h040, 32'h7000_1234, 32'h0, 1'b0, 1'b0, 1'b1, 32'h0000_0000, 1'b0, 1'b0, 4'd5}, // R5 imm asr 0 pos
      '{1'b0, 12'h240, 32'hF000_0008, 32'h0, 1'b0, 1'b0, 1'b0, 32'hFF00_0000, 1'b1, 1'b0, 4'd5}, // R5 imm asr 4
      '{1'b0, 12'h060, 32'h0000_0003, 32'h0, 1'b0, 1'b0, 1'b1, 32'h8000_0001, 1'b1, 1'b0, 4'd7}, // R7 rrx
      '{1'b0, 12'h460, 32'h1234_5678, 32'h0, 1'b0, 1'b0, 1'b1, 32'h7812_3456, 1'b0, 1'b0, 4'd6}, // R6 imm ror 8
      '{1'b0, 12'h000, 32'hDEAD_BEEF, 32'h0, 1'b0, 1'b0, 1'b1, 32'hDEAD_BEEF, 1'b1, 1'b0, 4'd8}, // R8 imm lsl 0
      '{1'b0, 12'h230, 32'h5555_AAAA, 32'h100, 1'b0, 1'b0, 1'b1, 32'h5555_AAAA, 1'b1, 1'b1, 4'd2}, // R2 reg lsr low8 0
      '{1'b0, 12'h270, 32'h0000_0001, 32'h300, 1'b0, 1'b0, 1'b1, 32'h0000_0001, 1'b1, 1'b1, 4'd2}, // R2 reg ror 0
      '{1'b0, 12'h250, 32'h8000_0000, 32'h0, 1'b0, 1'b0, 1'b0, 32'h8000_0000, 1'b0, 1'b1, 4'd2}, // R2 reg asr 0
      '{1'b0, 12'h210, 32'h8000_0001, 32'd1, 1'b0, 1'b0, 1'b0, 32'h0000_0002, 1'b1, 1'b1, 4'd3}, // R3 reg lsl 1
      '{1'b0, 12'h210, 32'h0000_0003, 32'd32, 1'b0, 1'b0, 1'b0, 32'h0, 1'b1, 1'b1, 4'd3}, // R3 reg lsl 32
      '{1'b0, 12'h210, 32'h0000_0003, 32'd33, 1'b0, 1'b0, 1'b1, 32'h0, 1'b0, 1'b1, 4'd3}, // R3 reg lsl 33
      '{1'b0, 12'h230, 32'h8000_0000, 32'd32, 1'b0, 1'b0, 1'b0, 32'h0, 1'b1, 1'b1, 4'd4}, // R4 reg lsr 32
      '{1'b0, 12'h230, 32'h8000_0000, 32'd40, 1'b0, 1'b0, 1'b1, 32'h0, 1'b0, 1'b1, 4'd4}, // R4 reg lsr 40
      '{1'b0, 12'h250, 32'h8000_0000, 32'd200, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF, 1'b1, 1'b1, 4'd5}, // R5 reg asr 200
      '{1'b0, 12'h250, 32'h7000_0000, 32'd32, 1'b0, 1'b0, 1'b1, 32'h0, 1'b0, 1'b1, 4'd5}, // R5 reg asr 32 pos
      '{1'b0, 12'h270, 32'h8000_0010, 32'd64, 1'b0, 1'b0, 1'b0, 32'h8000_0010, 1'b1, 1'b1, 4'd6}, // R6 reg ror 64
      '{1'b0, 12'h270, 32'h0000_00F8, 32'd36, 1'b0, 1'b0, 1'b0, 32'h8000_000F, 1'b1, 1'b1, 4'd6}, // R6 reg ror 36
      '{1'b0, 12'h210, 32'h0000_0100, 32'd0, 1'b1, 1'b1, 1'b1, 32'h0000_1040, 1'b0, 1'b1, 4'd1}, // R1 pc bump reg form
      '{1'b0, 12'h080, 32'h0000_0100, 32'd0, 1'b1, 1'b1, 1'b1, 32'h0000_0200, 1'b0, 1'b0, 4'd1}, // R1 no bump imm form
      '{1'b1, 12'h0AB, 32'hFFFF_FFFF, 32'd5, 1'b0, 1'b0, 1'b1, 32'h0000_00AB, 1'b1, 1'b0, 4'd9}, // R9 rot 0
      '{1'b1, 12'h4FF, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 32'hFF00_0000, 1'b1, 1'b0, 4'd9}, // R9 rot 8
      '{1'b1, 12'h1F1, 32'h0, 32'h0, 1'b0, 1'b0, 1'b1, 32'h4000_003C, 1'b0, 1'b0, 4'd9}  // R9 rot 2
   };

   task automatic check(input string req, input logic [31:0] eop, input logic ec, input logic ex);
      checks++;
      if (operand !== eop || carry_out !== ec || extra_cycle !== ex) begin
         errors++;
         $display("FAIL %s: got op=%h c=%b x=%b, expected op=%h c=%b x=%b",
                  req, operand, carry_out, extra_cycle, eop, ec, ex);
      end
   endtask

   task automatic apply(input vec_t v);
      @(posedge clk);
      imm_sel  = v.imm;
      op_field = v.op;
      rm_val   = v.rm;
      rs_val   = v.rs;
      rm_is_pc = v.rmpc;
      rs_is_pc = v.rspc;
      carry_in = v.cin;
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #100000;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      finish_run();
   end

   initial begin
      // R10 all-zero inputs
      repeat (2) @(negedge clk);
      check("R10", 32'h0, 1'b0, 1'b0);

      for (int i = 0; i < NV; i++) begin
         apply(VECS[i]);
         check($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].eop, VECS[i].ec, VECS[i].ex);
      end

      // R6 register rotate by 1 with carry from bit 0
      apply('{1'b0, 12'h270, 32'h0000_0003, 32'd1, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 4'd6});
      check("R6 ror1", 32'h8000_0001, 1'b1, 1'b1);
      // R4 register lsr 31 carry from bit 30
      apply('{1'b0, 12'h230, 32'h4000_0000, 32'd31, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 4'd4});
      check("R4 lsr31", 32'h0, 1'b1, 1'b1);
      // R3 rs low 8 bits only: 0x120 -> 32
      apply('{1'b0, 12'h210, 32'h0000_0001, 32'h0000_0120, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 4'd3});
      check("R3 lsl rs-low8", 32'h0, 1'b1, 1'b1);
      // R10 back to zero inputs
      apply('{1'b0, 12'h000, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 4'd10});
      check("R10 zero", 32'h0, 1'b0, 1'b0);

      finish_run();
   end
endmodule